// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block derives the serial clock of a two-wire bus master from the peripheral clock. A single waveform register holds three fields: a divisor for the low phase, a divisor for the high phase, and a power-of-two prescaler exponent that both divisors share. Each phase lasts the divisor shifted left by the exponent, plus a fixed offset of peripheral clocks. The offset is set at build time. The bus sequencer that sits beside this block uses the SCL level it drives and a one-cycle strobe that marks every change of that level.

The generator runs only while both the master enable and the run request are high. In every other state it releases SCL high and holds its phase counter at zero. During the high phase it counts only those cycles in which the sampled bus line is actually high. A slave that holds the line low therefore stretches the high phase by exactly the number of cycles it holds it. A new register value takes effect only at a phase boundary. A software reset input clears the register.

Top module: `two_wire_clkgen`

## Requirements
- R1: While running, each low phase keeps `scl_out` at 0 for exactly (lo_div << exp) + OFFSET clock cycles.
- R2: Each high phase keeps `scl_out` at 1 until (hi_div << exp) + OFFSET rising edges have seen `scl_in` high. Every cycle in which `scl_in` is sampled low lengthens the phase by one cycle.
- R3: Register layout on `cfg_wr_data`: low divisor in bits 7:0, high divisor in bits 15:8, exponent in bits 18:16. All higher bits are ignored.
- R4: An exponent value above MAX_EXP (default 5) acts as MAX_EXP.
- R5: When `master_en` or `gen_run` is low, `scl_out` is 1 from the next cycle on and the phase count restarts. When both are high again, a full low phase begins one cycle later.
- R6: A register write never changes the phase in progress. The new value governs every phase that starts after the next boundary.
- R7: `soft_rst` clears the register to zero, and it wins over a write in the same cycle. After that, both phases last OFFSET cycles.
- R8: `phase_tgl` is 1 in exactly those cycles in which `scl_out` differs from its value in the previous cycle.
- R9: After reset, `scl_out` is 1, `phase_tgl` is 0 and the register is zero, so a run with no write gives phases of OFFSET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the waveform register |
| cfg_wr_data | input | DATA_W | Write data for the waveform register |
| soft_rst | input | 1 | Clears the waveform register |
| master_en | input | 1 | Master function enable |
| gen_run | input | 1 | Run request from the bus sequencer |
| scl_in | input | 1 | Sampled level of the bus clock line |
| scl_out | output | 1 | Driven clock level; 1 means released |
| phase_tgl | output | 1 | One-cycle strobe on every change of `scl_out` |

## Verification
The hardest case is a slave stretching the clock partway through a high phase that has already begun counting. The bench reaches it by feeding `scl_in` from `scl_out` gated by a hold flag. It raises that flag a few cycles after a rise and keeps it up for a known number of cycles. A second hard case is a write landing mid-phase, and the bench times it from the observed toggles. Both cases are checked cycle by cycle against a behavioural model, and also by measuring phase lengths at the ports.

// File: rtl/twc_pkg.sv
package twc_pkg;

  localparam int DIV_W = 8;
  localparam int EXP_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Packed so that exp sits in [18:16], hi in [15:8], lo in [7:0]
  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [DIV_W-1:0] hi;
    logic [DIV_W-1:0] lo;
  } wave_cfg_t;

  localparam int CFG_W = $bits(wave_cfg_t);

endpackage

// File: rtl/twc_cfg_regs.sv
module twc_cfg_regs
  import twc_pkg::*;
#(
  parameter int MAX_EXP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_cfg,
  input  logic             soft_rst,
  input  logic             load_act,
  output wave_cfg_t        act_cfg
);

  localparam int EXP_MAX_ENC = (1 << EXP_W) - 1;

  wave_cfg_t prog_q, prog_d;
  wave_cfg_t act_q, act_d;
  wave_cfg_t prog_clamped;

  // programmed register: software reset has priority over a write
  always_comb begin
    prog_d = prog_q;
    if (soft_rst) begin
      prog_d = '0;
    end else if (wr_en) begin
      prog_d = wave_cfg_t'(wr_cfg);
    end
  end

  generate
    if (MAX_EXP < EXP_MAX_ENC) begin : g_clamp
      always_comb begin
        prog_clamped = prog_q;
        if (prog_q.exp > EXP_W'(MAX_EXP)) begin
          prog_clamped.exp = EXP_W'(MAX_EXP);
        end
      end
    end else begin : g_pass
      always_comb begin
        prog_clamped = prog_q;
      end
    end
  endgenerate

  // active copy only moves at a phase boundary
  always_comb begin
    act_d = act_q;
    if (load_act) begin
      act_d = prog_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      act_q  <= '0;
    end else begin
      prog_q <= prog_d;
      act_q  <= act_d;
    end
  end

  assign act_cfg = act_q;

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (prog_q == '0));

  // R4
  exp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.exp <= EXP_W'(MAX_EXP));

endmodule

// File: rtl/twc_len_calc.sv
module twc_len_calc
  import twc_pkg::*;
#(
  parameter int OFFSET = 4,
  parameter int CNT_W  = 13
) (
  input  logic [DIV_W-1:0] div,
  input  logic [EXP_W-1:0] exp,
  output logic [CNT_W-1:0] len_m1
);

  logic [CNT_W-1:0] scaled;

  // phase length minus one: (div << exp) + OFFSET - 1
  assign scaled = CNT_W'(div) << exp;
  assign len_m1 = scaled + CNT_W'(OFFSET - 1);

endmodule

// File: rtl/twc_phase_ctl.sv
module twc_phase_ctl
  import twc_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] lo_len_m1,
  input  logic [CNT_W-1:0] hi_len_m1,
  output logic             load_act,
  output logic             scl_q,
  output logic             tgl_q
);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur_len;
  logic             last_cnt;
  logic             scl_d, tgl_d;

  assign cur_len  = (st_q == PH_HIGH) ? hi_len_m1 : lo_len_m1;
  assign last_cnt = (cnt_q == cur_len);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    load_act = 1'b0;
    if (!enable) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d     = PH_LOW;
          cnt_d    = '0;
          load_act = 1'b1;
        end
        PH_LOW: begin
          if (last_cnt) begin
            st_d     = PH_HIGH;
            cnt_d    = '0;
            load_act = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          // count only while the line is really high (stretching)
          if (scl_in) begin
            if (last_cnt) begin
              st_d     = PH_LOW;
              cnt_d    = '0;
              load_act = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign scl_d = (st_d != PH_LOW);
  assign tgl_d = scl_d ^ scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      scl_q <= 1'b1;
      tgl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      scl_q <= scl_d;
      tgl_q <= tgl_d;
    end
  end

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_q && (cnt_q == '0)));

  // R2
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (st_q == PH_HIGH) && !scl_in) |=> ($stable(cnt_q) && (st_q == PH_HIGH)));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_IDLE) |-> (cnt_q <= cur_len));

endmodule

// File: rtl/two_wire_clkgen.sv
module two_wire_clkgen
  import twc_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic              soft_rst,
  input  logic              master_en,
  input  logic              gen_run,
  input  logic              scl_in,
  output logic              scl_out,
  output logic              phase_tgl
);

  localparam int MAX_LEN = (((1 << DIV_W) - 1) << MAX_EXP) + OFFSET;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             rst_meta_q, rst_sync_q;
  logic             gen_enable;
  logic             load_act;
  wave_cfg_t        act_cfg;
  logic [CNT_W-1:0] lo_len_m1, hi_len_m1;
  logic             unused_hi_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign gen_enable     = master_en & gen_run;
  assign unused_hi_bits = ^cfg_wr_data[DATA_W-1:CFG_W];

  twc_cfg_regs #(
    .MAX_EXP (MAX_EXP)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (cfg_wr_en),
    .wr_cfg   (cfg_wr_data[CFG_W-1:0]),
    .soft_rst (soft_rst),
    .load_act (load_act),
    .act_cfg  (act_cfg)
  );

  twc_len_calc #(
    .OFFSET (OFFSET),
    .CNT_W  (CNT_W)
  ) i_len_lo (
    .div    (act_cfg.lo),
    .exp    (act_cfg.exp),
    .len_m1 (lo_len_m1)
  );

  twc_len_calc #(
    .OFFSET (OFFSET),
    .CNT_W  (CNT_W)
  ) i_len_hi (
    .div    (act_cfg.hi),
    .exp    (act_cfg.exp),
    .len_m1 (hi_len_m1)
  );

  twc_phase_ctl #(
    .CNT_W (CNT_W)
  ) i_phase (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .enable    (gen_enable),
    .scl_in    (scl_in),
    .lo_len_m1 (lo_len_m1),
    .hi_len_m1 (hi_len_m1),
    .load_act  (load_act),
    .scl_q     (scl_out),
    .tgl_q     (phase_tgl)
  );

  // R8
  tgl_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    phase_tgl == (scl_out != $past(scl_out)));

  // R6
  cfg_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(act_cfg) |-> phase_tgl);

endmodule

// File: tb/test_two_wire_clkgen.sv
module test_two_wire_clkgen;

  localparam int OFFSET  = 4;
  localparam int MAX_EXP = 5;

  logic        clk = 1'b0;
  logic        rst_n, cfg_wr_en, soft_rst, master_en, gen_run, stretch_hold;
  logic [31:0] cfg_wr_data;
  logic        scl_in, scl_out, phase_tgl;

  always #4 clk = ~clk;

  assign scl_in = scl_out & ~stretch_hold;

  two_wire_clkgen i_two_wire_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .soft_rst    (soft_rst),
    .master_en   (master_en),
    .gen_run     (gen_run),
    .scl_in      (scl_in),
    .scl_out     (scl_out),
    .phase_tgl   (phase_tgl)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R9";
  bit    cmp_on = 1'b0;
  int    run_level = 1, run_len = 0, last_len = 0, last_level = 1;
  bit    tog = 1'b0;

  // behavioural reference model
  int m_st, m_rem, m_scl, m_tgl, prev_scl;
  int p_lo, p_hi, p_exp, a_lo, a_hi, a_exp;

  function automatic int plen(int d, int e);
    int ee;
    ee = (e > MAX_EXP) ? MAX_EXP : e;
    return (d << ee) + OFFSET;
  endfunction

  function automatic logic [31:0] mk(int lo, int hi, int ex);
    return 32'hFFF8_0000 | 32'((ex & 7) << 16) | 32'((hi & 255) << 8) | 32'(lo & 255);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_scl = 1; m_tgl = 0;
      p_lo = 0; p_hi = 0; p_exp = 0; a_lo = 0; a_hi = 0; a_exp = 0;
    end else begin
      prev_scl = m_scl;
      if (!(master_en && gen_run)) begin
        m_st = 0; m_rem = 0;
      end else begin
        case (m_st)
          0: begin
            a_lo = p_lo; a_hi = p_hi; a_exp = p_exp;
            m_st = 1; m_rem = plen(a_lo, a_exp);
          end
          1: begin
            if (m_rem == 1) begin
              a_lo = p_lo; a_hi = p_hi; a_exp = p_exp;
              m_st = 2; m_rem = plen(a_hi, a_exp);
            end else m_rem--;
          end
          default: begin
            if (scl_in) begin
              if (m_rem == 1) begin
                a_lo = p_lo; a_hi = p_hi; a_exp = p_exp;
                m_st = 1; m_rem = plen(a_lo, a_exp);
              end else m_rem--;
            end
          end
        endcase
      end
      if (soft_rst) begin
        p_lo = 0; p_hi = 0; p_exp = 0;
      end else if (cfg_wr_en) begin
        p_lo = int'(cfg_wr_data[7:0]);
        p_hi = int'(cfg_wr_data[15:8]);
        p_exp = int'(cfg_wr_data[18:16]);
      end
      m_scl = (m_st == 1) ? 0 : 1;
      m_tgl = (m_scl != prev_scl) ? 1 : 0;
    end
  end

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cmp_on) begin
      check(cur_req, int'(scl_out), m_scl, "scl_out vs model");
      check("R8", int'(phase_tgl), m_tgl, "phase_tgl vs model");
    end
    tog = 1'b0;
    if (int'(scl_out) != run_level) begin
      last_len = run_len; last_level = run_level;
      run_level = int'(scl_out); run_len = 1; tog = 1'b1;
    end else run_len++;
  endtask

  task automatic wait_edges(int n);
    int seen;
    seen = 0;
    while (seen < n) begin
      step();
      if (tog) seen++;
    end
  endtask

  task automatic wait_low_end();
    do step(); while (!(tog && last_level == 0));
  endtask

  task automatic write_cfg(logic [31:0] d, logic clr);
    cfg_wr_en = 1'b1; cfg_wr_data = d; soft_rst = clr;
    step();
    cfg_wr_en = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; soft_rst = 1'b0;
    master_en = 1'b0; gen_run = 1'b0; stretch_hold = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", int'(scl_out), 1, "scl_out in reset");
    check("R9", int'(phase_tgl), 0, "phase_tgl in reset");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) step();

    // R9: zero register gives OFFSET-long phases
    master_en = 1'b1; gen_run = 1'b1;
    wait_edges(2);
    check("R9", last_len, OFFSET, "low length after reset");
    wait_edges(1);
    check("R9", last_len, OFFSET, "high length after reset");

    // R3 / R1 / R2 basic pattern with junk in upper bits
    cur_req = "R5";
    gen_run = 1'b0;
    step();
    write_cfg(mk(2, 5, 1), 1'b0);
    step();
    cur_req = "R1";
    gen_run = 1'b1;
    wait_edges(2);
    check("R1", last_len, plen(2, 1), "low length");
    check("R3", last_len, 8, "low length from field 7:0");
    cur_req = "R2";
    wait_edges(1);
    check("R2", last_len, plen(5, 1), "high length");

    // R2 stretching in mid high phase
    wait_edges(1);
    repeat (3) step();
    stretch_hold = 1'b1;
    repeat (5) step();
    stretch_hold = 1'b0;
    wait_edges(1);
    check("R2", last_len, plen(5, 1) + 5, "stretched high length");

    // R6 mid-phase write
    cur_req = "R6";
    repeat (2) step();
    write_cfg(mk(6, 1, 0), 1'b0);
    wait_edges(1);
    check("R6", last_len, plen(2, 1), "low in progress unchanged");
    wait_edges(1);
    check("R6", last_len, plen(1, 0), "high after boundary");
    wait_edges(1);
    check("R6", last_len, plen(6, 0), "next low");

    // R4 exponent clamp
    cur_req = "R4";
    write_cfg(mk(1, 1, 7), 1'b0);
    wait_edges(1);
    wait_low_end();
    check("R4", last_len, (1 << MAX_EXP) + OFFSET, "clamped low");
    wait_edges(1);
    check("R4", last_len, (1 << MAX_EXP) + OFFSET, "clamped high");

    // R5 disable via run and via master enable
    cur_req = "R5";
    repeat (3) step();
    gen_run = 1'b0;
    step();
    check("R5", int'(scl_out), 1, "released after run drop");
    repeat (3) step();
    gen_run = 1'b1;
    wait_edges(2);
    check("R5", last_len, (1 << MAX_EXP) + OFFSET, "full low after restart");
    repeat (2) step();
    master_en = 1'b0;
    step();
    check("R5", int'(scl_out), 1, "released after master disable");
    step();
    master_en = 1'b1;
    wait_edges(2);
    check("R5", last_len, (1 << MAX_EXP) + OFFSET, "full low after re-enable");

    // R7 soft reset beats a simultaneous write
    cur_req = "R7";
    write_cfg(mk(9, 9, 3), 1'b1);
    wait_edges(1);
    wait_low_end();
    check("R7", last_len, OFFSET, "low after soft reset");
    wait_edges(1);
    check("R7", last_len, OFFSET, "high after soft reset");

    repeat (4) step();
    finish_run();
  end

endmodule